// File: doc/BRIEF.md
# Enhanced Parallel Port Transfer Gate

This block is the enhanced-mode front end of a parallel printer port. The host reaches it through a small register window. Offset 0 is the forward data latch, offset 1 is status, offset 2 is control, offset 3 launches an address cycle and offset 4 launches a data cycle. An address or data access only goes out to the peripheral link when the stored control bits hold the exact pattern for that direction. Otherwise a write is dropped without effect and a read returns all ones.

A launched access becomes a single request on a request/response link. The host is stalled until the peripheral answers or until a programmable cycle limit runs out. An error answer or an expired limit sets a sticky timeout flag. The flag replaces bit 0 of the peripheral status and is cleared only by a status write with bit 0 set. Control and data-latch writes that do not change the stored value are suppressed. A change of the direction bit raises a one-cycle direction event.

Top module: `epp_xfer_gate`

## Requirements
- R1: After reset the data latch reads 0xFF, control reads 0xCC, no link request is pending and the timeout flag is clear.
- R2: An address (offset 3) or data (offset 4) write launches a link request only when control AND 0x2F equals 0x04. Otherwise it is discarded, with no request and no state change.
- R3: An address or data read launches a link request only when control AND 0x2F equals 0x24. Otherwise it completes at once and returns all ones at the access width (0xFF, 0xFFFF or 0xFFFFFFFF).
- R4: Size code 0/1/2 (3 acts as 2) selects 1/2/4 bytes at offset 4, while offset 3 is always 1 byte. Byte 0 travels in bits 7:0 (little-endian). Data above the width is zero, both on the link and in the host read data.
- R5: A link response with the error bit set makes the timeout flag 1, and it stays 1 across later successful transfers.
- R6: A status read (offset 1) returns peripheral status bits 7:1 with the timeout flag in bit 0.
- R7: A status write with bit 0 = 1 clears the timeout flag. A status write with bit 0 = 0 leaves it unchanged.
- R8: A control write stores the written value OR 0xC0. If that equals the stored value, nothing happens. Otherwise a one-cycle control event is raised.
- R9: A control write that changes bit 5 (direction, 1 = read) raises a one-cycle direction event, and the direction output shows the new bit.
- R10: A data-latch write equal to the stored byte is suppressed. A different byte updates the latch and raises a one-cycle data event.
- R11: Only one link request is outstanding at a time, and the request is held until the response. If no response arrives within the timeout limit of waiting cycles, the access ends as an error: the flag is set and a read returns all ones at the width.
- R12: Reset during an outstanding request drops the request and clears the timeout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host access strobe, one cycle |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 3 | Register offset |
| hst_size | input | 2 | Access size code |
| hst_wdata | input | 32 | Host write data, little-endian |
| hst_rdata | output | 32 | Host read data, valid with hst_ack |
| hst_ack | output | 1 | Access complete, one cycle |
| tmo_limit | input | TMO_W | Waiting cycles allowed before expiry |
| pstat | input | 8 | Peripheral status lines |
| ctl_out | output | 8 | Stored control value |
| data_out | output | 8 | Stored data latch |
| data_evt | output | 1 | Data latch changed |
| ctl_evt | output | 1 | Control value changed |
| dir_evt | output | 1 | Direction bit changed |
| dir_val | output | 1 | Current direction bit |
| lnk_req | output | 1 | Link request, held until response |
| lnk_we | output | 1 | Link transfer is a write |
| lnk_adr_cyc | output | 1 | Link transfer is an address cycle |
| lnk_nbytes | output | 3 | Link transfer byte count |
| lnk_wdata | output | 32 | Link write data |
| lnk_rsp | input | 1 | Link response strobe |
| lnk_err | input | 1 | Response carries an error |
| lnk_rdata | input | 32 | Link read data |

## Verification
A wrong gate decision shows on the very next edge. A request rises on the link where none is due, or the host gets peripheral data where all ones were expected. A corrupted timeout flag does not show on its own. It appears only at the next status read, as a wrong bit 0, so the bench reads status after every flag-changing event. A stuck wait counter shows up as an acknowledge that arrives too early, too late or never, and the bench measures that latency against the limit.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam int HDW = 32;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_EADR = 3'd3;
  localparam logic [2:0] OFS_EDAT = 3'd4;
  localparam logic [7:0] GATE_MASK = 8'h2F;
  localparam logic [7:0] PAT_WR    = 8'h04;
  localparam logic [7:0] PAT_RD    = 8'h24;
  localparam logic [7:0] CTL_FIX   = 8'hC0;
  localparam logic [7:0] CTL_RST   = 8'hCC;
  localparam int DIR_BIT = 5;

  function automatic logic [HDW-1:0] width_mask(input logic [2:0] nb);
    case (nb)
      3'd1:    width_mask = 32'h0000_00FF;
      3'd2:    width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_gate_pkg::*;
(
  input  logic [7:0] ctl,
  input  logic       is_rd,
  output logic       open
);
  always_comb begin
    open = ((ctl & GATE_MASK) == (is_rd ? PAT_RD : PAT_WR));
  end
endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                        cnt_d = '0;
    else if (run && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q >= limit);
endmodule

// File: rtl/epp_link_ctrl.sv
module epp_link_ctrl
  import epp_gate_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           launch,
  input  logic           we_i,
  input  logic           adr_i,
  input  logic [2:0]     nb_i,
  input  logic [HDW-1:0] wdata_i,
  input  logic [7:0]     ctl_i,
  input  logic [TW-1:0]  tmo_limit,
  input  logic           lnk_rsp,
  input  logic           lnk_err,
  input  logic [HDW-1:0] lnk_rdata,
  output logic           busy,
  output logic           lnk_req,
  output logic           lnk_we,
  output logic           lnk_adr_cyc,
  output logic [2:0]     lnk_nbytes,
  output logic [HDW-1:0] lnk_wdata,
  output logic           done,
  output logic           done_err,
  output logic [HDW-1:0] done_rdata
);
  logic           busy_q, busy_d;
  logic           we_q, we_d, adr_q, adr_d;
  logic [2:0]     nb_q, nb_d;
  logic [HDW-1:0] wd_q, wd_d;
  logic           expire;

  epp_wait_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (launch),
    .run    (busy_q),
    .limit  (tmo_limit),
    .expire (expire)
  );

  always_comb begin
    done       = busy_q && (lnk_rsp || expire);
    done_err   = done && (!lnk_rsp || lnk_err);
    done_rdata = (lnk_rsp ? lnk_rdata : {HDW{1'b1}}) & width_mask(nb_q);
  end

  always_comb begin
    busy_d = busy_q;
    we_d   = we_q;
    adr_d  = adr_q;
    nb_d   = nb_q;
    wd_d   = wd_q;
    if (busy_q) begin
      if (done) busy_d = 1'b0;
    end else if (launch) begin
      busy_d = 1'b1;
      we_d   = we_i;
      adr_d  = adr_i;
      nb_d   = nb_i;
      wd_d   = wdata_i & width_mask(nb_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      adr_q  <= 1'b0;
      nb_q   <= 3'd1;
      wd_q   <= '0;
    end else begin
      busy_q <= busy_d;
      we_q   <= we_d;
      adr_q  <= adr_d;
      nb_q   <= nb_d;
      wd_q   <= wd_d;
    end
  end

  assign busy        = busy_q;
  assign lnk_req     = busy_q;
  assign lnk_we      = we_q;
  assign lnk_adr_cyc = adr_q;
  assign lnk_nbytes  = nb_q;
  assign lnk_wdata   = wd_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_req && !lnk_rsp && !expire) |=> lnk_req);
  // R2 R3
  gate_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lnk_req) |-> ((ctl_i & GATE_MASK) == (lnk_we ? PAT_WR : PAT_RD)));
  // R11
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_req && !done) |=> $stable(lnk_wdata) && $stable(lnk_nbytes));
endmodule

// File: rtl/epp_xfer_gate.sv
module epp_xfer_gate
  import epp_gate_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_req,
  input  logic             hst_we,
  input  logic [2:0]       hst_addr,
  input  logic [1:0]       hst_size,
  input  logic [31:0]      hst_wdata,
  output logic [31:0]      hst_rdata,
  output logic             hst_ack,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic [7:0]       pstat,
  output logic [7:0]       ctl_out,
  output logic [7:0]       data_out,
  output logic             data_evt,
  output logic             ctl_evt,
  output logic             dir_evt,
  output logic             dir_val,
  output logic             lnk_req,
  output logic             lnk_we,
  output logic             lnk_adr_cyc,
  output logic [2:0]       lnk_nbytes,
  output logic [31:0]      lnk_wdata,
  input  logic             lnk_rsp,
  input  logic             lnk_err,
  input  logic [31:0]      lnk_rdata
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [7:0]  data_q, data_d, ctl_q, ctl_d;
  logic        flag_q, flag_d, ack_q, ack_d;
  logic [31:0] rdata_q, rdata_d;
  logic        devt_q, devt_d, cevt_q, cevt_d, revt_q, revt_d;

  logic        busy, xfer_done, xfer_err, gate_open;
  logic [31:0] xfer_rdata;
  logic        acc, is_epp, launch, local_acc;
  logic [2:0]  nb;
  logic [7:0]  ctl_new;
  logic [31:0] loc_rd;

  epp_cycle_gate u_gate (
    .ctl   (ctl_q),
    .is_rd (!hst_we),
    .open  (gate_open)
  );

  always_comb begin
    acc       = hst_req && !busy;
    is_epp    = (hst_addr == OFS_EADR) || (hst_addr == OFS_EDAT);
    launch    = acc && is_epp && gate_open;
    local_acc = acc && !launch;
    if (hst_addr == OFS_EADR) nb = 3'd1;
    else begin
      case (hst_size)
        2'd0:    nb = 3'd1;
        2'd1:    nb = 3'd2;
        default: nb = 3'd4;
      endcase
    end
    ctl_new = hst_wdata[7:0] | CTL_FIX;
    case (hst_addr)
      OFS_DATA: loc_rd = {24'd0, data_q};
      OFS_STAT: loc_rd = {24'd0, (pstat & 8'hFE) | {7'd0, flag_q}};
      OFS_CTRL: loc_rd = {24'd0, ctl_q};
      OFS_EADR, OFS_EDAT: loc_rd = width_mask(nb);
      default:  loc_rd = 32'h0000_00FF;
    endcase
  end

  epp_link_ctrl #(.TW(TMO_W)) u_link (
    .clk         (clk),
    .rst_n       (rst_sync),
    .launch      (launch),
    .we_i        (hst_we),
    .adr_i       (hst_addr == OFS_EADR),
    .nb_i        (nb),
    .wdata_i     (hst_wdata),
    .ctl_i       (ctl_q),
    .tmo_limit   (tmo_limit),
    .lnk_rsp     (lnk_rsp),
    .lnk_err     (lnk_err),
    .lnk_rdata   (lnk_rdata),
    .busy        (busy),
    .lnk_req     (lnk_req),
    .lnk_we      (lnk_we),
    .lnk_adr_cyc (lnk_adr_cyc),
    .lnk_nbytes  (lnk_nbytes),
    .lnk_wdata   (lnk_wdata),
    .done        (xfer_done),
    .done_err    (xfer_err),
    .done_rdata  (xfer_rdata)
  );

  always_comb begin
    data_d  = data_q;
    ctl_d   = ctl_q;
    flag_d  = flag_q;
    rdata_d = rdata_q;
    ack_d   = 1'b0;
    devt_d  = 1'b0;
    cevt_d  = 1'b0;
    revt_d  = 1'b0;
    if (xfer_done) begin
      ack_d = 1'b1;
      if (!lnk_we) rdata_d = xfer_rdata;
      if (xfer_err) flag_d = 1'b1;
    end
    if (local_acc) begin
      ack_d = 1'b1;
      if (!hst_we) rdata_d = loc_rd;
      else begin
        case (hst_addr)
          OFS_DATA: if (hst_wdata[7:0] != data_q) begin
            data_d = hst_wdata[7:0];
            devt_d = 1'b1;
          end
          OFS_STAT: if (hst_wdata[0]) flag_d = 1'b0;
          OFS_CTRL: if (ctl_new != ctl_q) begin
            ctl_d  = ctl_new;
            cevt_d = 1'b1;
            revt_d = (ctl_new[DIR_BIT] != ctl_q[DIR_BIT]);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      data_q  <= 8'hFF;
      ctl_q   <= CTL_RST;
      flag_q  <= 1'b0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
      devt_q  <= 1'b0;
      cevt_q  <= 1'b0;
      revt_q  <= 1'b0;
    end else begin
      data_q  <= data_d;
      ctl_q   <= ctl_d;
      flag_q  <= flag_d;
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
      devt_q  <= devt_d;
      cevt_q  <= cevt_d;
      revt_q  <= revt_d;
    end
  end

  assign hst_ack   = ack_q;
  assign hst_rdata = rdata_q;
  assign ctl_out   = ctl_q;
  assign data_out  = data_q;
  assign data_evt  = devt_q;
  assign ctl_evt   = cevt_q;
  assign dir_evt   = revt_q;
  assign dir_val   = ctl_q[DIR_BIT];

  // R5
  err_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (lnk_req && lnk_rsp && lnk_err) |=> flag_q);
  // R9
  dir_evt_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    dir_evt |-> (ctl_evt && ($past(ctl_out[DIR_BIT]) != ctl_out[DIR_BIT])));
  // R8
  ctl_fixed_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    ctl_out[7:6] == 2'b11);
  // R10
  data_evt_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    data_evt |-> (data_out != $past(data_out)));
endmodule

// File: tb/test_epp_xfer_gate.sv
module test_epp_xfer_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_req = 1'b0, hst_we = 1'b0;
  logic [2:0]  hst_addr = '0;
  logic [1:0]  hst_size = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        hst_ack;
  logic [15:0] tmo_limit = 16'd40;
  logic [7:0]  pstat = 8'h80;
  logic [7:0]  ctl_out, data_out;
  logic        data_evt, ctl_evt, dir_evt, dir_val;
  logic        lnk_req, lnk_we, lnk_adr_cyc;
  logic [2:0]  lnk_nbytes;
  logic [31:0] lnk_wdata;
  logic        lnk_rsp = 1'b0, lnk_err = 1'b0;
  logic [31:0] lnk_rdata = '0;

  always #10 clk = ~clk;

  epp_xfer_gate i_epp_xfer_gate (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  typedef struct { bit rd; logic [31:0] exp; string tag; } sb_t;
  sb_t sb_q[$];

  // peripheral model and event counters
  int per_dly = 2, per_cnt = 0, launches = 0;
  int n_devt = 0, n_cevt = 0, n_revt = 0;
  bit per_en = 1, per_err = 0, req_prev = 0;
  logic [31:0] per_rd = 32'hAABBCCDD;
  logic        cap_we, cap_adr;
  logic [2:0]  cap_nb;
  logic [31:0] cap_wd;

  always @(negedge clk) begin
    if (data_evt) n_devt++;
    if (ctl_evt)  n_cevt++;
    if (dir_evt)  n_revt++;
    if (lnk_req && !req_prev) begin
      launches++;
      cap_we = lnk_we; cap_adr = lnk_adr_cyc; cap_nb = lnk_nbytes; cap_wd = lnk_wdata;
    end
    req_prev = lnk_req;
    if (lnk_rsp) begin
      lnk_rsp = 0; lnk_err = 0; per_cnt = 0;
    end else if (!lnk_req) per_cnt = 0;
    else if (per_en) begin
      if (per_cnt == per_dly) begin
        lnk_rsp = 1; lnk_err = per_err; lnk_rdata = per_rd;
      end else per_cnt++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (hst_ack) begin
      if (sb_q.size() == 0) check(0, "R11 unexpected ack", 32'd1, 32'd0);
      else begin
        sb_t it = sb_q.pop_front();
        if (it.rd) check(hst_rdata == it.exp, it.tag, hst_rdata, it.exp);
      end
    end
  end

  int lat;
  task automatic access(input bit we, input logic [2:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] exp, input string tag);
    sb_t it;
    it.rd = !we; it.exp = exp; it.tag = tag;
    @(negedge clk);
    sb_q.push_back(it);
    hst_req = 1; hst_we = we; hst_addr = a; hst_size = sz; hst_wdata = wd;
    @(negedge clk);
    hst_req = 0;
    lat = 0;
    while (!hst_ack) begin @(negedge clk); lat++; end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int l0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1
    check(lnk_req == 0, "R1 no request", lnk_req, 0);
    check(ctl_out == 8'hCC, "R1 control", ctl_out, 8'hCC);
    check(data_out == 8'hFF, "R1 data", data_out, 8'hFF);
    access(0, 3'd1, 0, 0, 32'h80, "R1 R6 status flag clear");
    // R2 closed gate writes
    l0 = launches;
    access(1, 3'd4, 2, 32'h11223344, 0, "R2");
    access(1, 3'd3, 0, 32'h5A, 0, "R2");
    check(launches == l0, "R2 closed write no request", launches, l0);
    // R3 closed gate reads
    access(0, 3'd4, 0, 0, 32'h000000FF, "R3 byte ones");
    access(0, 3'd4, 1, 0, 32'h0000FFFF, "R3 half ones");
    access(0, 3'd4, 2, 0, 32'hFFFFFFFF, "R3 word ones");
    access(0, 3'd3, 2, 0, 32'h000000FF, "R3 addr ones");
    check(launches == l0, "R3 closed read no request", launches, l0);
    // R8 control write
    access(1, 3'd2, 0, 32'h04, 0, "R8");
    check(ctl_out == 8'hC4 && n_cevt == 1, "R8 control change event", {ctl_out, n_cevt[7:0]}, {8'hC4, 8'd1});
    check(n_revt == 0, "R9 no dir event", n_revt, 0);
    access(1, 3'd2, 0, 32'hC4, 0, "R8");
    check(n_cevt == 1, "R8 identical write silent", n_cevt, 1);
    // R2 R4 open gate writes
    access(1, 3'd4, 2, 32'h11223344, 0, "R2");
    check(launches == l0 + 1 && cap_we && !cap_adr && cap_nb == 4, "R2 R4 word write launch",
          {launches[7:0], 5'd0, cap_nb}, {l0[7:0] + 8'd1, 8'd4});
    check(cap_wd == 32'h11223344, "R4 little-endian word", cap_wd, 32'h11223344);
    access(1, 3'd3, 2, 32'hFFFF_FF5A, 0, "R4");
    check(cap_adr && cap_nb == 1 && cap_wd == 32'h5A, "R4 address byte", cap_wd, 32'h5A);
    access(0, 3'd4, 0, 0, 32'hFF, "R3 read at write pattern");
    // R9 direction change
    access(1, 3'd2, 0, 32'h24, 0, "R9");
    check(n_revt == 1 && dir_val == 1, "R9 dir event to read", {n_revt[7:0], 7'd0, dir_val}, 16'h0101);
    l0 = launches;
    access(1, 3'd4, 0, 32'h77, 0, "R2");
    check(launches == l0, "R2 write at read pattern dropped", launches, l0);
    access(0, 3'd4, 1, 0, 32'h0000CCDD, "R4 half read");
    access(0, 3'd4, 0, 0, 32'h000000DD, "R4 byte read");
    access(0, 3'd4, 2, 0, 32'hAABBCCDD, "R4 word read");
    access(0, 3'd1, 0, 0, 32'h80, "R6 flag still clear");
    // R5 error
    per_err = 1;
    access(0, 3'd3, 0, 0, 32'hDD, "R5 error read");
    per_err = 0;
    access(0, 3'd4, 0, 0, 32'hDD, "R5 good read");
    pstat = 8'h00;
    access(0, 3'd1, 0, 0, 32'h01, "R5 R6 flag sticky");
    pstat = 8'hFF;
    access(0, 3'd1, 0, 0, 32'hFF, "R6 status bits");
    // R7
    access(1, 3'd1, 0, 32'hFE, 0, "R7");
    pstat = 8'h00;
    access(0, 3'd1, 0, 0, 32'h01, "R7 bit0 zero no clear");
    access(1, 3'd1, 0, 32'h01, 0, "R7");
    pstat = 8'hFF;
    access(0, 3'd1, 0, 0, 32'hFE, "R7 cleared");
    // R11 timeout
    per_en = 0; tmo_limit = 16'd6;
    access(0, 3'd4, 1, 0, 32'h0000FFFF, "R11 timed-out read");
    check(lat >= 6 && lat <= 9, "R11 timeout latency", lat, 6);
    access(0, 3'd1, 0, 0, 32'hFF, "R11 flag after expiry");
    per_en = 1;
    // R9 back to write direction
    access(1, 3'd2, 0, 32'h04, 0, "R9");
    check(n_revt == 2 && dir_val == 0, "R9 dir event to write", {n_revt[7:0], 7'd0, dir_val}, 16'h0200);
    // R10
    access(1, 3'd0, 0, 32'h55, 0, "R10");
    check(n_devt == 1 && data_out == 8'h55, "R10 data change", {n_devt[7:0], data_out}, 16'h0155);
    access(1, 3'd0, 0, 32'h55, 0, "R10");
    check(n_devt == 1, "R10 repeat suppressed", n_devt, 1);
    access(0, 3'd0, 0, 0, 32'h55, "R10 latch readback");
    // R12 reset with outstanding request
    per_en = 0; tmo_limit = 16'd1000;
    @(negedge clk);
    hst_req = 1; hst_we = 1; hst_addr = 3'd4; hst_size = 0; hst_wdata = 32'h9;
    @(negedge clk);
    hst_req = 0;
    repeat (3) @(negedge clk);
    check(lnk_req == 1, "R11 request held", lnk_req, 1);
    rst_n = 0;
    @(negedge clk);
    check(lnk_req == 0, "R12 request dropped", lnk_req, 0);
    rst_n = 1; per_en = 1;
    repeat (4) @(negedge clk);
    pstat = 8'h00;
    access(0, 3'd1, 0, 0, 32'h00, "R12 flag cleared");
    check(ctl_out == 8'hCC, "R12 control reset", ctl_out, 8'hCC);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule